// File: doc/BRIEF.md
# F-Bit Data Link Inserter

This block sits on the serial transmit path of a T1 framer, after the frame formatter. It takes over the framing-bit slot of selected frames and sends a host-programmed overhead pattern in its place. The pattern lives in a circular store of six 6-bit words. Together these form a 36-bit sequence that repeats once every 36 insertions. A control bit chooses whether the even-numbered or the odd-numbered frames carry the pattern. A 6-bit mask chooses, by bit position within a word, which slots take pattern data and which keep the formatter's bit.

The host may rewrite any pattern word while the link is running. A word is copied into a holding register when its first bit (bit 5) is sent. A rewrite therefore never tears a word that is partly sent. It shows up the next time that word comes round. A multiframe-alignment strobe, sampled together with the frame-start strobe, marks frame 1 (odd) and restarts the pattern at word 0, bit 5.

The serial stream has no back-pressure. One line bit enters and one leaves on every clock, so there is no valid or ready handshake. Downstream logic must take `line_out` on every cycle. The output is always exactly one register stage behind `line_in`.

Top module: `fbit_link_inserter`

## Requirements
- R1: After reset `line_out` is 0, the frame parity is even and the pattern pointer is at word 0, bit 5. The first insertion after enable, with no alignment, takes word 0 bit 5.
- R2: On every cycle where `fbit_strobe` is low, `line_out` in the next cycle equals `line_in` of this cycle.
- R3: With `sel_odd`=0, insertion happens only on the F-bit of even frames. F-bits of odd frames pass `line_in` through and leave the pointer unchanged.
- R4: With `sel_odd`=1, insertion happens only on the F-bit of odd frames. F-bits of even frames pass `line_in` through and leave the pointer unchanged.
- R5: The pattern is sent as word 0 bit 5 down to bit 0, then word 1, and so on to word 5. After 36 insertions it wraps back to word 0, bit 5.
- R6: On a selected F-bit, if the mask bit with the same index as the current bit position is 1, the pattern bit is sent. If it is 0, `line_in` is sent. The pointer advances in both cases.
- R7: A word is latched when its bit 5 is sent. A host write to that word afterwards does not change its bits 4..0 now in flight. The new value is used on the next fetch of that word. A write in the same cycle as the fetch is not seen by that fetch.
- R8: A cycle with `frame_start` and `mf_align` both high makes the current frame odd (frame 1). It also moves the pointer to word 0, bit 5, and an F-bit in that same cycle already uses the restarted pointer. `frame_start` alone toggles the frame parity.
- R9: Host writes with `host_addr` of 6 or 7 change no pattern word.
- R10: With `enable`=0, `line_out` equals `line_in` delayed by one cycle and the pointer holds. Frame parity keeps tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock, one bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Serial data from the frame formatter |
| frame_start | input | 1 | High on the first bit cycle of each frame |
| fbit_strobe | input | 1 | High on the cycle that carries the F-bit |
| mf_align | input | 1 | Multiframe alignment; acts only with frame_start |
| host_we | input | 1 | Pattern word write strobe |
| host_addr | input | 3 | Pattern word index 0..5 |
| host_wdata | input | 6 | Pattern word value, bit 5 sent first |
| enable | input | 1 | 1 enables insertion |
| sel_odd | input | 1 | 0 selects even frames, 1 selects odd frames |
| bit_mask | input | 6 | Per-position insert enable, index = bit position |
| line_out | output | 1 | Serial data with F-bits overlaid |

## Verification
The bench drives a full multiframe past the 36th insertion to catch an off-by-one wrap, which would repeat or skip a word. It runs even and odd selection from a known alignment, so an inverted parity check puts the pattern into the wrong frames. It rewrites a word just after its bit 5 goes out and rewrites the next word before its fetch. Reading the store live would corrupt the word in flight, and a stale copy would miss the update. A sparse mask, a mid-multiframe realignment and writes to the unused addresses 6 and 7 expose a pointer that stalls on masked slots, a restart that lags a frame, and address aliasing.

// File: rtl/fbit_pkg.sv
package fbit_pkg;
  typedef enum logic {PAR_EVEN = 1'b0, PAR_ODD = 1'b1} fpar_e;
  localparam int DEF_WORD_W  = 6;
  localparam int DEF_N_WORDS = 6;
  localparam int DEF_ADDR_W  = 3;
endpackage

// File: rtl/fbit_pattern_buf.sv
module fbit_pattern_buf #(
  parameter int WORD_W  = fbit_pkg::DEF_WORD_W,
  parameter int N_WORDS = fbit_pkg::DEF_N_WORDS,
  parameter int ADDR_W  = fbit_pkg::DEF_ADDR_W,
  localparam int PTR_W  = $clog2(N_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic [N_WORDS-1:0][WORD_W-1:0] store_q;

  for (genvar i = 0; i < N_WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) store_q[i] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(i)) store_q[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_WORDS; i++)
      if (rd_addr == PTR_W'(i)) rd_data = store_q[i];
  end

  // R9: an address past the last word leaves every word untouched
  a_r9_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= ADDR_W'(N_WORDS)) |=> $stable(store_q));
endmodule

// File: rtl/fbit_frame_tracker.sv
module fbit_frame_tracker
  import fbit_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  frame_start,
  input  logic  mf_align,
  output fpar_e par_now,
  output logic  mf_restart
);
  fpar_e par_q;

  assign mf_restart = frame_start & mf_align;

  always_comb begin
    par_now = par_q;
    if (mf_restart)       par_now = PAR_ODD;
    else if (frame_start) par_now = (par_q == PAR_ODD) ? PAR_EVEN : PAR_ODD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) par_q <= PAR_EVEN;
    else        par_q <= par_now;
  end

  // R8: alignment marks frame 1
  a_r8_align_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && mf_align) |=> par_q == PAR_ODD);
  // R3: plain frame start alternates parity
  a_r3_parity_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !mf_align) |=> par_q != $past(par_q));
  a_r3_parity_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(par_q));
endmodule

// File: rtl/fbit_bit_sequencer.sv
module fbit_bit_sequencer
  import fbit_pkg::*;
#(
  parameter int WORD_W  = fbit_pkg::DEF_WORD_W,
  parameter int N_WORDS = fbit_pkg::DEF_N_WORDS,
  localparam int PTR_W  = $clog2(N_WORDS),
  localparam int BIT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fbit_strobe,
  input  logic              enable,
  input  logic              sel_odd,
  input  fpar_e             par_now,
  input  logic              mf_restart,
  input  logic [WORD_W-1:0] bit_mask,
  output logic [PTR_W-1:0]  rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic              ins_valid,
  output logic              ins_bit
);
  localparam logic [BIT_W-1:0] TOP_BIT   = BIT_W'(WORD_W - 1);
  localparam logic [PTR_W-1:0] LAST_WORD = PTR_W'(N_WORDS - 1);

  logic [PTR_W-1:0]  word_q, word_eff;
  logic [BIT_W-1:0]  bit_q, bit_eff;
  logic [WORD_W-1:0] hold_q;
  logic              take, at_top;
  fpar_e             want;

  assign want     = sel_odd ? PAR_ODD : PAR_EVEN;
  assign word_eff = mf_restart ? '0 : word_q;
  assign bit_eff  = mf_restart ? TOP_BIT : bit_q;
  assign at_top   = (bit_eff == TOP_BIT);
  assign take     = fbit_strobe & enable & (par_now == want);
  assign rd_addr  = word_eff;

  always_comb begin
    ins_bit = 1'b0;
    for (int k = 0; k < WORD_W; k++)
      if (bit_eff == BIT_W'(k)) ins_bit = at_top ? rd_data[k] : hold_q[k];
  end

  always_comb begin
    ins_valid = 1'b0;
    for (int k = 0; k < WORD_W; k++)
      if (bit_eff == BIT_W'(k)) ins_valid = take & bit_mask[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      bit_q  <= TOP_BIT;
      hold_q <= '0;
    end else if (take) begin
      if (at_top) hold_q <= rd_data;
      if (bit_eff == '0) begin
        bit_q  <= TOP_BIT;
        word_q <= (word_eff == LAST_WORD) ? '0 : word_eff + PTR_W'(1);
      end else begin
        bit_q  <= bit_eff - BIT_W'(1);
        word_q <= word_eff;
      end
    end else if (mf_restart) begin
      word_q <= '0;
      bit_q  <= TOP_BIT;
    end
  end

  // R5: pointer stays inside the pattern
  a_r5_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    (word_q <= LAST_WORD) && (bit_q <= TOP_BIT));
  // R5: wrap after the last bit of the last word
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (take && word_eff == LAST_WORD && bit_eff == '0) |=> (word_q == '0 && bit_q == TOP_BIT));
  // R10: no selected F-bit, no restart: pointer holds
  a_r10_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !mf_restart) |=> ($stable(word_q) && $stable(bit_q)));
  // R8: restart without insertion lands on word 0 bit 5
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_restart && !take) |=> (word_q == '0 && bit_q == TOP_BIT));
  // R7: the latched word changes only at a fetch
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && at_top) |=> $stable(hold_q));
endmodule

// File: rtl/fbit_link_inserter.sv
module fbit_link_inserter
  import fbit_pkg::*;
#(
  parameter int WORD_W  = fbit_pkg::DEF_WORD_W,
  parameter int N_WORDS = fbit_pkg::DEF_N_WORDS,
  parameter int ADDR_W  = fbit_pkg::DEF_ADDR_W,
  localparam int PTR_W  = $clog2(N_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  input  logic              frame_start,
  input  logic              fbit_strobe,
  input  logic              mf_align,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              enable,
  input  logic              sel_odd,
  input  logic [WORD_W-1:0] bit_mask,
  output logic              line_out
);
  fpar_e             par_now;
  logic              mf_restart, ins_valid, ins_bit;
  logic [PTR_W-1:0]  rd_addr;
  logic [WORD_W-1:0] rd_data;

  fbit_pattern_buf #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .ADDR_W(ADDR_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(host_we), .wr_addr(host_addr),
    .wr_data(host_wdata), .rd_addr(rd_addr), .rd_data(rd_data));

  fbit_frame_tracker u_frm (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .mf_align(mf_align),
    .par_now(par_now), .mf_restart(mf_restart));

  fbit_bit_sequencer #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .fbit_strobe(fbit_strobe), .enable(enable),
    .sel_odd(sel_odd), .par_now(par_now), .mf_restart(mf_restart),
    .bit_mask(bit_mask), .rd_addr(rd_addr), .rd_data(rd_data),
    .ins_valid(ins_valid), .ins_bit(ins_bit));

  always_ff @(posedge clk) begin
    if (!rst_n) line_out <= 1'b0;
    else        line_out <= ins_valid ? ins_bit : line_in;
  end

  // R2: non-F-bit cycles are a pure one-cycle delay
  a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    !fbit_strobe |=> line_out == $past(line_in));
  // R10: disabled inserter is a pure one-cycle delay
  a_r10_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> line_out == $past(line_in));
endmodule

// File: tb/tb_fbit_link_inserter.sv
module tb_fbit_link_inserter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_in = 1'b0, frame_start = 1'b0, fbit_strobe = 1'b0, mf_align = 1'b0;
  logic host_we = 1'b0;
  logic [2:0] host_addr = '0;
  logic [5:0] host_wdata = '0;
  logic enable = 1'b0, sel_odd = 1'b0;
  logic [5:0] bit_mask = 6'h3F;
  logic line_out;

  fbit_link_inserter dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .frame_start(frame_start),
    .fbit_strobe(fbit_strobe), .mf_align(mf_align), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .enable(enable),
    .sel_odd(sel_odd), .bit_mask(bit_mask), .line_out(line_out));

  always #10 clk = ~clk; // 50 MHz

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;
  // bench model of the requirements
  logic [5:0] m_buf [6];
  int   m_w = 0, m_b = 5;
  logic m_par = 1'b0;
  logic [5:0] m_hold = '0;
  bit   pend = 0;
  logic pend_exp;
  string pend_tag;

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0b exp %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input logic fs, input logic fp, input logic al,
                      input logic we, input logic [2:0] wa, input logic [5:0] wd,
                      input string tag);
    logic bi, o, d;
    @(negedge clk);
    if (pend) chk(line_out, pend_exp, pend_tag);
    bi = lfsr[0];
    lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    line_in = bi; frame_start = fs; fbit_strobe = fp; mf_align = al;
    host_we = we; host_addr = wa; host_wdata = wd;
    o = bi;
    if (fs) begin
      if (al) begin m_par = 1'b1; m_w = 0; m_b = 5; end
      else m_par = ~m_par;
    end
    if (fp && enable && (m_par == sel_odd)) begin
      if (m_b == 5) m_hold = m_buf[m_w];
      d = m_hold[m_b];
      if (bit_mask[m_b]) o = d;
      if (m_b == 0) begin m_b = 5; m_w = (m_w + 1) % 6; end
      else m_b--;
    end
    if (we && wa < 3'd6) m_buf[wa] = wd;
    pend = 1; pend_exp = o; pend_tag = tag;
  endtask

  task automatic frame(input logic al, input string tag);
    step(1, 1, al, 0, 3'd0, 6'd0, tag);
    repeat (3) step(0, 0, 0, 0, 3'd0, 6'd0, "R2");
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [5:0] d, input string tag);
    step(0, 0, 0, 1, a, d, tag);
  endtask

  task automatic load_pattern(input string tag);
    hwrite(3'd0, 6'h2D, tag); hwrite(3'd1, 6'h13, tag); hwrite(3'd2, 6'h3A, tag);
    hwrite(3'd3, 6'h05, tag); hwrite(3'd4, 6'h2E, tag); hwrite(3'd5, 6'h19, tag);
  endtask

  task automatic t_reset_start();
    chk(line_out, 1'b0, "R1");
    load_pattern("R1");
    enable = 1; sel_odd = 0; bit_mask = 6'h3F;
    repeat (8) frame(0, "R1"); // first even frame takes word 0 bit 5
  endtask

  task automatic t_disabled();
    enable = 0;
    repeat (6) frame(0, "R10");
    enable = 1;
    repeat (4) frame(0, "R10");
  endtask

  task automatic t_even();
    sel_odd = 0; bit_mask = 6'h3F;
    frame(1, "R3");
    repeat (20) frame(0, "R3");
    repeat (60) frame(0, "R5"); // passes the 36-insertion wrap
  endtask

  task automatic t_odd();
    sel_odd = 1;
    frame(1, "R4");
    repeat (40) frame(0, "R4");
  endtask

  task automatic t_mask();
    sel_odd = 0; bit_mask = 6'b101001;
    frame(1, "R6");
    repeat (40) frame(0, "R6");
    bit_mask = 6'h3F;
  endtask

  task automatic t_live();
    sel_odd = 1;
    frame(1, "R7");                // word 0 bit 5 fetched here
    hwrite(3'd0, 6'h12, "R7");     // must not touch bits 4..0 in flight
    hwrite(3'd1, 6'h2A, "R7");     // must be seen at next fetch of word 1
    repeat (20) frame(0, "R7");
    step(1, 1, 1, 1, 3'd0, 6'h3F, "R7"); // write same cycle as fetch
    repeat (3) step(0, 0, 0, 0, 3'd0, 6'd0, "R7");
    repeat (80) frame(0, "R7");
  endtask

  task automatic t_align();
    sel_odd = 0;
    repeat (7) frame(0, "R8");
    frame(1, "R8");                // mid-multiframe restart, odd frame
    repeat (6) frame(0, "R8");
    sel_odd = 1;
    frame(1, "R8");                // F-bit in align cycle uses restarted pointer
    repeat (6) frame(0, "R8");
  endtask

  task automatic t_badaddr();
    hwrite(3'd6, 6'h00, "R9");
    hwrite(3'd7, 6'h3F, "R9");
    sel_odd = 0;
    frame(1, "R9");
    repeat (74) frame(0, "R9");
  endtask

  initial begin
    for (int i = 0; i < 6; i++) m_buf[i] = '0;
    line_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset_start();
    t_disabled();
    t_even();
    t_odd();
    t_mask();
    t_live();
    t_align();
    t_badaddr();
    step(0, 0, 0, 0, 3'd0, 6'd0, "R2");
    @(negedge clk);
    if (pend) chk(line_out, pend_exp, pend_tag);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule